// File: doc/BRIEF.md
# Spawn-Join Thread Dispatcher

This block hands out virtual thread numbers to a fixed group of lightweight thread units for one parallel region. A serial controller opens the region by presenting a lowest and a highest thread number. The block accepts that request and passes it to every unit in the same cycle. Unit `i` starts with thread number `low + i`. Each unit then runs its threads at its own pace. When a unit reports that its thread is finished, it claims the next number from one shared counter by an atomic fetch-and-increment. There is no fixed division of the range between units, so the load balances itself.

A unit whose claimed number is past the upper bound goes idle. It does not spin. When every unit is idle, the block gives the controller a single join pulse, and the controller can then go back to serial work. Thread bodies are modelled only as a per-unit finish strobe.

Top module: `spawn_dispatch`

## Requirements
- R1: After reset `busy` is 0, `join_done` is 0, and every bit of `tcu_active` and `tcu_start` is 0.
- R2: A `spawn_req` seen while `busy` is 0 is accepted. `busy` is 1 from the next cycle until the cycle in which `join_done` is 1.
- R3: In the cycle after acceptance, unit `i` has `tcu_start[i]`=1 and `tcu_tid` slice `i` (bits `i*ID_W` upward) equal to `spawn_lo + i`, provided that value is not above `spawn_hi`.
- R4: A unit whose first number `spawn_lo + i` is above `spawn_hi` is inactive from the cycle after acceptance and never pulses `tcu_start`. An empty range (low above high) starts no unit at all.
- R5: The shared counter starts at `spawn_lo + N_TCU`. A `tcu_done[i]` pulse from an active unit obtains the counter's current value and adds one to it. The new number appears with a `tcu_start[i]` pulse one cycle later.
- R6: Units that finish in the same cycle are all served in that cycle. They receive consecutive numbers, with the lowest unit index getting the lowest number.
- R7: A unit whose obtained number is above the high bound drops `tcu_active` one cycle later and does not pulse `tcu_start`.
- R8: `join_done` is a one-cycle pulse. It comes in the cycle after the last active unit retires, and `busy` falls in that same cycle.
- R9: A `spawn_req` while `busy` is 1 is ignored. No unit restarts and the counter keeps its value.
- R10: `tcu_done[i]` from an inactive unit is ignored. It produces no start and claims no number.
- R11: Over one region, every number from low to high is issued exactly once, whatever the order in which units finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spawn_req | input | 1 | Request to open a parallel region |
| spawn_lo | input | ID_W | Lowest thread number of the region |
| spawn_hi | input | ID_W | Highest thread number of the region |
| busy | output | 1 | A region is in progress |
| join_done | output | 1 | One-cycle pulse when all units have retired |
| tcu_done | input | N_TCU | Per-unit finish strobe for the current thread |
| tcu_start | output | N_TCU | Per-unit pulse: a new thread number was assigned |
| tcu_active | output | N_TCU | Per-unit running flag |
| tcu_tid | output | N_TCU*ID_W | Per-unit current thread number, packed by unit |

## Verification
Every result is exactly one register stage behind the edge that causes it:
- A thread number and its start pulse follow the accepting edge or the finish edge by one cycle.
- A retire shows on `tcu_active` one cycle after its finish strobe.
- `join_done` and the fall of `busy` come one cycle after the last retire.

The bench changes inputs only on falling edges. It reads outputs on the next falling edge, which is the first point where the response is due. Each directed task checks the join pulse on the second falling edge after the final finish strobes.

// File: rtl/sjd_pkg.sv
package sjd_pkg;
    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_RUN  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/grant_rank.sv
// Prefix count of simultaneous requests: each requester's offset into the
// shared counter, plus the total number granted this cycle.
module grant_rank #(
    parameter int N  = 4,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]         req,
    output logic [N-1:0][CW-1:0] offs,
    output logic [CW-1:0]        total
);
    always_comb begin
        logic [CW-1:0] acc;
        acc = '0;
        for (int i = 0; i < N; i++) begin
            offs[i] = acc;
            acc     = acc + CW'(req[i]);
        end
        total = acc;
    end
endmodule

// File: rtl/tcu_slot.sv
// Per-unit state: running flag, current thread number, start pulse.
module tcu_slot
    import sjd_pkg::*;
#(
    parameter int ID_W = 8,
    parameter int W1   = ID_W + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [W1-1:0]   first_id,
    input  logic [W1-1:0]   grant_id,
    input  logic [W1-1:0]   hi,
    input  logic            done,
    output logic            req,
    output logic            active,
    output logic            start,
    output logic [ID_W-1:0] tid
);
    typedef struct packed {
        slot_state_e     st;
        logic            start;
        logic [ID_W-1:0] tid;
    } slot_t;

    slot_t s_d, s_q;

    assign req    = (s_q.st == SLOT_RUN) && done;
    assign active = (s_q.st == SLOT_RUN);
    assign start  = s_q.start;
    assign tid    = s_q.tid;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        if (load) begin
            if (first_id <= hi) begin
                s_d.st    = SLOT_RUN;
                s_d.tid   = first_id[ID_W-1:0];
                s_d.start = 1'b1;
            end else begin
                s_d.st = SLOT_IDLE;
            end
        end else if (req) begin
            if (grant_id <= hi) begin
                s_d.tid   = grant_id[ID_W-1:0];
                s_d.start = 1'b1;
            end else begin
                s_d.st = SLOT_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SLOT_IDLE, start: 1'b0, tid: '0};
        else        s_q <= s_d;
    end

    // R3
    start_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.start |-> ({2'b00, s_q.tid} <= hi));

    // R5
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !done && !load) |=> (active && $stable(tid) && !start));
endmodule

// File: rtl/spawn_dispatch.sv
module spawn_dispatch #(
    parameter int N_TCU = 4,
    parameter int ID_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spawn_req,
    input  logic [ID_W-1:0]         spawn_lo,
    input  logic [ID_W-1:0]         spawn_hi,
    output logic                    busy,
    output logic                    join_done,
    input  logic [N_TCU-1:0]        tcu_done,
    output logic [N_TCU-1:0]        tcu_start,
    output logic [N_TCU-1:0]        tcu_active,
    output logic [N_TCU*ID_W-1:0]   tcu_tid
);
    localparam int W1 = ID_W + 2;
    localparam int CW = $clog2(N_TCU + 1);

    typedef struct packed {
        logic          busy;
        logic          joined;
        logic [W1-1:0] hi;
        logic [W1-1:0] cnt;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic                    load;
    logic [N_TCU-1:0]        req;
    logic [N_TCU-1:0][CW-1:0] offs;
    logic [CW-1:0]           total;
    logic [W1-1:0]           lo_w;

    assign lo_w = {2'b00, spawn_lo};
    assign load = spawn_req && !c_q.busy;

    grant_rank #(.N(N_TCU), .CW(CW)) u_rank (
        .req   (req),
        .offs  (offs),
        .total (total)
    );

    for (genvar g = 0; g < N_TCU; g++) begin : g_slot
        tcu_slot #(.ID_W(ID_W), .W1(W1)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .first_id (lo_w + W1'(g)),
            .grant_id (c_q.cnt + W1'(offs[g])),
            .hi       (c_q.busy ? c_q.hi : {2'b00, spawn_hi}),
            .done     (tcu_done[g]),
            .req      (req[g]),
            .active   (tcu_active[g]),
            .start    (tcu_start[g]),
            .tid      (tcu_tid[g*ID_W +: ID_W])
        );
    end

    always_comb begin
        c_d        = c_q;
        c_d.joined = 1'b0;
        if (load) begin
            c_d.busy = 1'b1;
            c_d.hi   = {2'b00, spawn_hi};
            c_d.cnt  = lo_w + W1'(N_TCU);
        end else if (c_q.busy) begin
            c_d.cnt = c_q.cnt + W1'(total);
            if (tcu_active == '0) begin
                c_d.busy   = 1'b0;
                c_d.joined = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy      = c_q.busy;
    assign join_done = c_q.joined;

    // R2
    accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spawn_req && !busy) |=> busy);

    // R8
    join_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        join_done |-> (!busy && tcu_active == '0 && $past(busy)));

    // R9
    counter_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (c_q.cnt >= $past(c_q.cnt)));

    // R10
    idle_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tcu_active == '0) |=> (tcu_start == '0));
endmodule

// File: tb/sim_spawn_dispatch.sv
`timescale 1ns/1ps
module sim_spawn_dispatch;
    localparam int N = 4;
    localparam int W = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic spawn_req = 0;
    logic [W-1:0] spawn_lo = 0, spawn_hi = 0;
    logic busy, join_done;
    logic [N-1:0] tcu_done = 0, tcu_start, tcu_active;
    logic [N*W-1:0] tcu_tid;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spawn_dispatch #(.N_TCU(N), .ID_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .spawn_req(spawn_req), .spawn_lo(spawn_lo),
        .spawn_hi(spawn_hi), .busy(busy), .join_done(join_done),
        .tcu_done(tcu_done), .tcu_start(tcu_start), .tcu_active(tcu_active),
        .tcu_tid(tcu_tid)
    );

    function automatic logic [W-1:0] tid_of(int i);
        return tcu_tid[i*W +: W];
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    task automatic do_spawn(int lo, int hi);
        spawn_lo = W'(lo); spawn_hi = W'(hi); spawn_req = 1;
        step;
        spawn_req = 0;
    endtask

    task automatic t_reset;
        chk("R1 busy", busy, 0);
        chk("R1 join", join_done, 0);
        chk("R1 active", tcu_active, 0);
        chk("R1 start", tcu_start, 0);
    endtask

    task automatic t_main;
        do_spawn(10, 20);
        chk("R2 busy", busy, 1);
        chk("R3 start", tcu_start, 4'b1111);
        for (int i = 0; i < N; i++) chk("R3 tid", tid_of(i), 10 + i);
        tcu_done = 4'b0100; step; tcu_done = 0;
        chk("R5 start", tcu_start, 4'b0100);
        chk("R5 tid", tid_of(2), 14);
        tcu_done = 4'b1001; step; tcu_done = 0;
        chk("R6 start", tcu_start, 4'b1001);
        chk("R6 tid0", tid_of(0), 15);
        chk("R6 tid3", tid_of(3), 16);
        spawn_lo = 0; spawn_hi = 0; spawn_req = 1; step; spawn_req = 0;
        chk("R9 start", tcu_start, 0);
        chk("R9 tid0", tid_of(0), 15);
        chk("R9 busy", busy, 1);
        tcu_done = 4'b0010; step; tcu_done = 0;
        chk("R9 counter kept tid1", tid_of(1), 17);
        tcu_done = 4'b1111; step; tcu_done = 0;
        chk("R7 start", tcu_start, 4'b0111);
        chk("R7 active", tcu_active, 4'b0111);
        chk("R7 tid0", tid_of(0), 18);
        chk("R7 tid2", tid_of(2), 20);
        tcu_done = 4'b1000; step; tcu_done = 0;
        chk("R10 start", tcu_start, 0);
        chk("R10 active", tcu_active, 4'b0111);
        tcu_done = 4'b0111; step; tcu_done = 0;
        chk("R7 retire all", tcu_active, 0);
        chk("R8 no early join", join_done, 0);
        chk("R8 busy held", busy, 1);
        step;
        chk("R8 join", join_done, 1);
        chk("R8 busy fall", busy, 0);
        step;
        chk("R8 pulse width", join_done, 0);
    endtask

    task automatic t_small;
        do_spawn(5, 6);
        chk("R4 start", tcu_start, 4'b0011);
        chk("R4 active", tcu_active, 4'b0011);
        chk("R4 tid1", tid_of(1), 6);
        tcu_done = 4'b0011; step; tcu_done = 0;
        chk("R7 active", tcu_active, 0);
        step;
        chk("R8 join small", join_done, 1);
    endtask

    task automatic t_empty;
        do_spawn(7, 6);
        chk("R4 empty start", tcu_start, 0);
        chk("R4 empty active", tcu_active, 0);
        chk("R4 empty busy", busy, 1);
        step;
        chk("R8 join empty", join_done, 1);
        chk("R8 busy empty", busy, 0);
    endtask

    task automatic t_cover;
        int seen [256];
        logic [7:0] lf = 8'h5a;
        bit joined = 0;
        for (int k = 0; k < 256; k++) seen[k] = 0;
        do_spawn(100, 130);
        for (int cyc = 0; cyc < 500 && !joined; cyc++) begin
            for (int i = 0; i < N; i++)
                if (tcu_start[i]) seen[tid_of(i)]++;
            if (join_done) joined = 1;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            tcu_done = tcu_active & lf[3:0];
            step;
        end
        tcu_done = 0;
        chk("R11 joined", int'(joined), 1);
        for (int k = 0; k < 256; k++)
            chk("R11 once", seen[k], (k >= 100 && k <= 130) ? 1 : 0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step; step;
        t_reset;
        rst_n = 1;
        step;
        t_main;
        t_small;
        step;
        t_empty;
        step;
        t_cover;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule